// File: doc/BRIEF.md
# BAR Address Window Decoder

This block sits beside the configuration register file of a bus endpoint. It takes the six base address register words, the expansion ROM register and the command register, and works out for each region whether a legal decode window exists and where that window starts. An incoming transaction address, tagged as I/O or memory space, is then compared against every legal window. One cycle later the block reports a one-hot region hit and the offset of the address within the winning region.

Region sizes are fixed powers of two chosen by parameters. Each BAR is declared as I/O or memory at build time, and a size exponent of zero marks a BAR as absent. The ROM region is always memory space. Window legality is derived combinationally from the register inputs, so a register change applies to the address presented in the same cycle.

Top module: `bar_window_decoder`

## Requirements
- R1: A window's base is the register word with its low L bits cleared (L is the region's size exponent) and its end is base + 2^L - 1. A request hits a region only when its space flag matches the region type (reqIsIo=1 for I/O regions, 0 for memory regions and the ROM) and base <= address <= end.
- R2: I/O regions decode only while command bit 0 is 1.
- R3: Memory regions and the ROM decode only while command bit 1 is 1.
- R4: The ROM region additionally decodes only while bit 0 of the ROM register is 1.
- R5: A window whose base is zero never decodes.
- R6: An I/O window whose end is 0x10000 or higher never decodes.
- R7: A memory window whose end is 0xFFFFFFFF never decodes, and no window whose end wraps past the top of the address space decodes.
- R8: A BAR whose size exponent is 0 (absent) never decodes.
- R9: hitVec has bit i for BAR i and bit 6 (the bit after the last BAR) for the ROM; when several legal windows contain the address, only the lowest-numbered region's bit is set.
- R10: hitOffset equals address minus the winning window's base (at most L bits wide), and is zero when no region hits.
- R11: The result is registered: the address and the register words presented before a clock edge give the outputs after that edge, so a register change takes effect for the address compared in the same cycle.
- R12: While reqValid is 0 no region hits, and reset clears hitVec and hitOffset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| barWords | input | NUM_BARS*32 | BAR words, BAR i in bits [32*i+31:32*i] |
| romWord | input | 32 | Expansion ROM register, bit 0 is the ROM enable |
| cmdWord | input | 16 | Command register, bit 0 I/O enable, bit 1 memory enable |
| reqValid | input | 1 | A transaction address is presented |
| reqAddr | input | 32 | Transaction address |
| reqIsIo | input | 1 | 1 for I/O space, 0 for memory space |
| hitVec | output | NUM_BARS+1 | One-hot region hit, ROM in the top bit |
| hitOffset | output | 32 | Offset within the hit region |

## Verification
The checks take for granted that every input is stable around the sampling clock edge, so the past value of the command, ROM and request inputs seen one edge back is the one the registered hit was computed from; the bench changes inputs only on the falling edge. They also assume the size exponents stay at or below 32 and the ROM exponent is at least 1, so the ROM enable bit is always among the masked low bits; the default parameters keep within that. The stimulus steers windows deliberately onto the illegal cases (zero base, I/O past 64 KiB, memory ending at all ones) and onto overlaps, rather than relying on random addresses to reach them.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
  localparam int WORD_W = 32;
  localparam int LOG2_W = 8;
  localparam int CMD_W = 16;
  localparam int CMD_IO_BIT = 0;
  localparam int CMD_MEM_BIT = 1;
  localparam int ROM_EN_BIT = 0;
  localparam logic [WORD_W:0] IO_LIMIT = 33'h0_0001_0000;

  // strobes from control to datapath
  typedef struct packed {
    logic ioOn;
    logic memOn;
    logic romOn;
    logic cmpOn;
  } decStrobes_t;
endpackage

// File: rtl/bar_dec_ctrl.sv
module bar_dec_ctrl
  import bar_dec_pkg::*;
(
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [WORD_W-1:0] romWord,
  input  logic              reqValid,
  output decStrobes_t       strobes
);
  always_comb begin
    strobes.ioOn  = cmdWord[CMD_IO_BIT];
    strobes.memOn = cmdWord[CMD_MEM_BIT];
    strobes.romOn = romWord[ROM_EN_BIT];
    strobes.cmpOn = reqValid;
  end
endmodule

// File: rtl/bar_dec_datapath.sv
module bar_dec_datapath
  import bar_dec_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*LOG2_W-1:0] BAR_LOG2 = {8'd16, 8'd4, 8'd0, 8'd20, 8'd8, 8'd12},
  parameter logic [NUM_BARS-1:0] BAR_IO = 6'b010010,
  parameter int ROM_LOG2 = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_BARS*WORD_W-1:0] barWords,
  input  logic [WORD_W-1:0]          romWord,
  input  logic [WORD_W-1:0]          reqAddr,
  input  logic                       reqIsIo,
  input  decStrobes_t                strobes,
  output logic [NUM_BARS:0]          hitVec,
  output logic [WORD_W-1:0]          hitOffset
);
  localparam int NUM_REG = NUM_BARS + 1;
  localparam int EXT_W = WORD_W + 1;
  localparam logic [EXT_W-1:0] TOP_END = {1'b0, {WORD_W{1'b1}}};

  logic [WORD_W-1:0] rawWord  [NUM_REG];
  logic [LOG2_W-1:0] sizeLog2 [NUM_REG];
  logic [EXT_W-1:0]  sizeM1   [NUM_REG];
  logic [EXT_W-1:0]  winBase  [NUM_REG];
  logic [EXT_W-1:0]  winEnd   [NUM_REG];
  logic [NUM_REG-1:0] isIoReg, spaceOn, winOk, match;
  logic [EXT_W-1:0] reqExt;
  logic [NUM_REG-1:0] nextVec;
  logic [WORD_W-1:0] nextOff;

  assign reqExt = {1'b0, reqAddr};

  for (genvar g = 0; g < NUM_REG; g++) begin : g_region
    if (g < NUM_BARS) begin : g_bar
      assign rawWord[g]  = barWords[g*WORD_W +: WORD_W];
      assign sizeLog2[g] = BAR_LOG2[g*LOG2_W +: LOG2_W];
      assign isIoReg[g]  = BAR_IO[g];
      assign spaceOn[g]  = BAR_IO[g] ? strobes.ioOn : strobes.memOn;
    end else begin : g_rom
      assign rawWord[g]  = romWord;
      assign sizeLog2[g] = LOG2_W'(ROM_LOG2);
      assign isIoReg[g]  = 1'b0;
      assign spaceOn[g]  = strobes.memOn & strobes.romOn;
    end

    assign sizeM1[g]  = (EXT_W'(1) << sizeLog2[g]) - EXT_W'(1);
    assign winBase[g] = {1'b0, rawWord[g]} & ~sizeM1[g];
    assign winEnd[g]  = winBase[g] + sizeM1[g];

    // legality: present, enabled, nonzero base, no wrap, space limit
    assign winOk[g] = spaceOn[g]
                    && (sizeLog2[g] != '0)
                    && (winBase[g] != '0)
                    && (winEnd[g] > winBase[g])
                    && !winEnd[g][WORD_W]
                    && (isIoReg[g] ? (winEnd[g] < IO_LIMIT)
                                   : (winEnd[g] != TOP_END));

    assign match[g] = strobes.cmpOn && winOk[g]
                    && (isIoReg[g] == reqIsIo)
                    && (reqExt >= winBase[g])
                    && (reqExt <= winEnd[g]);
  end

  // lowest-numbered match wins: scan downward, last assignment stands
  always_comb begin
    nextVec = '0;
    nextOff = '0;
    for (int i = NUM_REG - 1; i >= 0; i--) begin
      if (match[i]) begin
        nextVec = NUM_REG'(1) << i;
        nextOff = reqAddr & sizeM1[i][WORD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitVec    <= '0;
      hitOffset <= '0;
    end else begin
      hitVec    <= nextVec;
      hitOffset <= nextOff;
    end
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_dec_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*LOG2_W-1:0] BAR_LOG2 = {8'd16, 8'd4, 8'd0, 8'd20, 8'd8, 8'd12},
  parameter logic [NUM_BARS-1:0] BAR_IO = 6'b010010,
  parameter int ROM_LOG2 = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_BARS*WORD_W-1:0] barWords,
  input  logic [WORD_W-1:0]          romWord,
  input  logic [CMD_W-1:0]           cmdWord,
  input  logic                       reqValid,
  input  logic [WORD_W-1:0]          reqAddr,
  input  logic                       reqIsIo,
  output logic [NUM_BARS:0]          hitVec,
  output logic [WORD_W-1:0]          hitOffset
);
  decStrobes_t strobes;

  bar_dec_ctrl uCtrl (
    .cmdWord (cmdWord),
    .romWord (romWord),
    .reqValid(reqValid),
    .strobes (strobes)
  );

  bar_dec_datapath #(
    .NUM_BARS(NUM_BARS),
    .BAR_LOG2(BAR_LOG2),
    .BAR_IO  (BAR_IO),
    .ROM_LOG2(ROM_LOG2)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .barWords (barWords),
    .romWord  (romWord),
    .reqAddr  (reqAddr),
    .reqIsIo  (reqIsIo),
    .strobes  (strobes),
    .hitVec   (hitVec),
    .hitOffset(hitOffset)
  );
endmodule

// File: rtl/bar_window_decoder_chk.sv
module bar_window_decoder_chk
  import bar_dec_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*LOG2_W-1:0] BAR_LOG2 = {8'd16, 8'd4, 8'd0, 8'd20, 8'd8, 8'd12},
  parameter logic [NUM_BARS-1:0] BAR_IO = 6'b010010,
  parameter int ROM_LOG2 = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] romWord,
  input logic [CMD_W-1:0]  cmdWord,
  input logic              reqValid,
  input logic              reqIsIo,
  input logic [NUM_BARS:0] hitVec,
  input logic [WORD_W-1:0] hitOffset
);
  localparam logic [NUM_BARS:0] IO_MASK  = {1'b0, BAR_IO};
  localparam logic [NUM_BARS:0] MEM_MASK = {1'b1, ~BAR_IO};

  // R9
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R12
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |-> $past(reqValid));

  // R2
  io_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hitVec & IO_MASK) != '0) |-> $past(cmdWord[CMD_IO_BIT]));

  // R3
  mem_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hitVec & MEM_MASK) != '0) |-> $past(cmdWord[CMD_MEM_BIT]));

  // R4
  rom_needs_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitVec[NUM_BARS] |-> $past(romWord[ROM_EN_BIT]));

  // R1
  io_space_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hitVec & IO_MASK) != '0) |-> $past(reqIsIo));

  // R1
  mem_space_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hitVec & MEM_MASK) != '0) |-> !$past(reqIsIo));

  // R10
  offset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec == '0) |-> (hitOffset == '0));

  for (genvar g = 0; g <= NUM_BARS; g++) begin : g_reg_chk
    localparam int L = (g < NUM_BARS) ? int'(BAR_LOG2[(g % NUM_BARS)*LOG2_W +: LOG2_W]) : ROM_LOG2;
    if (L == 0) begin : g_absent
      // R8
      absent_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
        !hitVec[g]);
    end else if (L < WORD_W) begin : g_sized
      // R10
      offset_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        hitVec[g] |-> ((hitOffset >> L) == '0));
    end
  end
endmodule

bind bar_window_decoder bar_window_decoder_chk #(
  .NUM_BARS(NUM_BARS),
  .BAR_LOG2(BAR_LOG2),
  .BAR_IO  (BAR_IO),
  .ROM_LOG2(ROM_LOG2)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .romWord  (romWord),
  .cmdWord  (cmdWord),
  .reqValid (reqValid),
  .reqIsIo  (reqIsIo),
  .hitVec   (hitVec),
  .hitOffset(hitOffset)
);

// File: tb/bar_window_decoder_test.sv
module bar_window_decoder_test;
  localparam int NB = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] barReg [NB];
  logic [NB*32-1:0] barWords;
  logic [31:0] romWord = '0;
  logic [15:0] cmdWord = '0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic reqIsIo = 1'b0;
  logic [NB:0] hitVec;
  logic [31:0] hitOffset;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [6:0] NONE = 7'b0000000;
  localparam logic [6:0] B0 = 7'b0000001;
  localparam logic [6:0] B1 = 7'b0000010;
  localparam logic [6:0] B2 = 7'b0000100;
  localparam logic [6:0] B4 = 7'b0010000;
  localparam logic [6:0] B5 = 7'b0100000;
  localparam logic [6:0] ROM = 7'b1000000;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NB; i++) barWords[i*32 +: 32] = barReg[i];

  bar_window_decoder uut (
    .clk(clk), .rstN(rstN), .barWords(barWords), .romWord(romWord),
    .cmdWord(cmdWord), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqIsIo(reqIsIo), .hitVec(hitVec), .hitOffset(hitOffset)
  );

  task automatic compare(input logic [6:0] ev, input logic [31:0] eo, input string tag);
    checks++;
    if (hitVec !== ev || hitOffset !== eo) begin
      errors++;
      $display("FAIL %s: hit=%b off=%h expected hit=%b off=%h", tag, hitVec, hitOffset, ev, eo);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic io, input logic v,
                       input logic [6:0] ev, input logic [31:0] eo, input string tag);
    @(negedge clk);
    reqAddr = a; reqIsIo = io; reqValid = v;
    @(negedge clk);
    compare(ev, eo, tag);
  endtask

  task automatic baseCfg();
    barReg[0] = 32'h8000_1000; barReg[1] = 32'h0000_C001;
    barReg[2] = 32'h9000_0000; barReg[3] = 32'hA000_0000;
    barReg[4] = 32'h0000_D001; barReg[5] = 32'hB000_0000;
    romWord = 32'hC000_0001; cmdWord = 16'h0003;
  endtask

  task automatic testReset();
    compare(NONE, 32'h0, "R12 reset state");
  endtask

  task automatic testBasic();
    baseCfg();
    probe(32'h8000_1234, 1'b0, 1'b1, B0, 32'h234, "R1 mem mid window");
    probe(32'h8000_1FFF, 1'b0, 1'b1, B0, 32'hFFF, "R1 mem last byte");
    probe(32'h8000_2000, 1'b0, 1'b1, NONE, 32'h0, "R1 R10 past end");
    probe(32'h0000_C010, 1'b1, 1'b1, B1, 32'h10, "R1 io hit");
    probe(32'h0000_C010, 1'b0, 1'b1, NONE, 32'h0, "R1 space mismatch");
    probe(32'h0000_D00F, 1'b1, 1'b1, B4, 32'hF, "R1 small io last");
    probe(32'h0000_D010, 1'b1, 1'b1, NONE, 32'h0, "R1 small io past end");
    probe(32'hB000_ABCD, 1'b0, 1'b1, B5, 32'hABCD, "R1 bar5 hit");
  endtask

  task automatic testEnables();
    baseCfg();
    cmdWord = 16'h0002;
    probe(32'h0000_C010, 1'b1, 1'b1, NONE, 32'h0, "R2 io disabled");
    probe(32'h8000_1010, 1'b0, 1'b1, B0, 32'h10, "R2 mem unaffected");
    cmdWord = 16'h0001;
    probe(32'h8000_1010, 1'b0, 1'b1, NONE, 32'h0, "R3 mem disabled");
    probe(32'hC000_0010, 1'b0, 1'b1, NONE, 32'h0, "R3 rom disabled");
    probe(32'h0000_C020, 1'b1, 1'b1, B1, 32'h20, "R3 io unaffected");
  endtask

  task automatic testRom();
    baseCfg();
    probe(32'hC000_FFFF, 1'b0, 1'b1, ROM, 32'hFFFF, "R4 rom enabled");
    romWord = 32'hC000_0000;
    probe(32'hC000_1234, 1'b0, 1'b1, NONE, 32'h0, "R4 rom bit clear");
  endtask

  task automatic testIllegal();
    baseCfg();
    barReg[0] = 32'h0000_0FFF;
    probe(32'h0000_0010, 1'b0, 1'b1, NONE, 32'h0, "R5 mem base zero");
    barReg[4] = 32'h0000_0001;
    probe(32'h0000_0005, 1'b1, 1'b1, NONE, 32'h0, "R5 io base zero");
    barReg[1] = 32'h0001_0001;
    probe(32'h0001_0010, 1'b1, 1'b1, NONE, 32'h0, "R6 io above 64K");
    barReg[1] = 32'h0000_FF01;
    probe(32'h0000_FFFF, 1'b1, 1'b1, B1, 32'hFF, "R6 io ends at FFFF");
    barReg[5] = 32'hFFFF_0000;
    probe(32'hFFFF_0010, 1'b0, 1'b1, NONE, 32'h0, "R7 mem ends all ones");
    barReg[5] = 32'hFFFE_0000;
    probe(32'hFFFE_FFFF, 1'b0, 1'b1, B5, 32'hFFFF, "R7 mem just below top");
    probe(32'hA000_0010, 1'b0, 1'b1, NONE, 32'h0, "R8 absent bar");
  endtask

  task automatic testPriority();
    baseCfg();
    barReg[0] = 32'h9000_0000;
    probe(32'h9000_0100, 1'b0, 1'b1, B0, 32'h100, "R9 overlap lowest wins");
    probe(32'h9000_1100, 1'b0, 1'b1, B2, 32'h1100, "R9 outside small window");
  endtask

  task automatic testTiming();
    baseCfg();
    @(negedge clk);
    barReg[0] = 32'h7000_0000;
    reqAddr = 32'h7000_0008; reqIsIo = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    compare(B0, 32'h8, "R11 config change same cycle");
    probe(32'h7000_0008, 1'b0, 1'b0, NONE, 32'h0, "R12 valid low");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < NB; i++) barReg[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testBasic();
    testEnables();
    testRom();
    testIllegal();
    testPriority();
    testTiming();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish();
  end
endmodule